// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide flash memory whose program and erase algorithms are timed from outside the part. It observes a memory-style bus (active-low chip select, write strobe and read strobe, plus address and data) and brings those pins into a synchronous clock domain. It decodes command bytes written over that bus and chooses what a read returns: the addressed array byte, a fixed identifier byte, or the byte at a location latched earlier for verification.

Some commands act on a single write. Program and erase need a setup write followed by a second write, and the second write is what starts the operation. When it is accepted, the controller issues a one-cycle program or erase strobe toward the storage array. The program strobe comes with the latched target address and byte. The erase strobe applies to the entire array. The array itself is outside this block: the controller only forms the array read address and takes the array read byte back in.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and after a write of 8'h00 or 8'hFF, a read returns the array byte at the address presented on that read.
- R2: After a write of 8'h90, a read at an address whose low byte is 8'h00 returns 8'h01, low byte 8'h01 returns 8'hA7, and any other low byte returns 8'h00.
- R3: A write of 8'h20 followed by a second write of 8'h20 raises the erase strobe exactly once, after which reads return array data.
- R4: A write of 8'h20 followed by any second value other than 8'h20 raises no erase strobe and returns the controller to array reads.
- R5: A write of 8'h40 followed by a second write raises the program strobe once, with the address and data of that second write on the program address and data outputs.
- R6: A write of 8'hA0 latches the address of that write; subsequent reads return the array byte at that latched address, whatever address the read presents.
- R7: A write of 8'hC0 makes subsequent reads return the array byte at the address of the most recent program operation.
- R8: Two consecutive writes of 8'hFF return the controller to array reads from any state other than the program setup, including a pending erase setup, without any strobe.
- R9: A first-cycle write of any byte other than 8'h00, 8'hFF, 8'h90, 8'h20, 8'hA0, 8'h40 and 8'hC0 leaves the current read mode unchanged.
- R10: A write takes its address from the bus when the write strobe falls and its data from the bus when the write strobe rises; a write strobe pulse is counted as exactly one write.
- R11: A write strobe pulse is ignored unless chip select is low and the read strobe is high.
- R12: The data output is enabled only while chip select and the read strobe are low and the write strobe is high; otherwise dq_oe is 0 and dq_out is 8'h00.
- R13: The program and erase strobes are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | 17 | Bus address |
| dq_in | input | 8 | Bus data toward the device |
| dq_out | output | 8 | Read data from the device |
| dq_oe | output | 1 | Drive enable for the data bus |
| arr_raddr | output | 17 | Array read address |
| arr_rdata | input | 8 | Array read data |
| prog_pulse | output | 1 | One-cycle program strobe |
| prog_addr | output | 17 | Latched program address |
| prog_data | output | 8 | Latched program data |
| erase_pulse | output | 1 | One-cycle whole-array erase strobe |

## Verification
The assertions check on every cycle that each strobe lasts one cycle, that an erase or program strobe only follows its matching setup state, that a write event never repeats in back-to-back cycles, and that an identifier command written outside a setup state lands in identifier mode. Only the bench scenarios can show the read-side results: the identifier bytes across a sweep of addresses, verify reads that ignore the presented address, the full sweep of unrecognised command bytes, and the timing of address and data capture, where the address is changed after the strobe falls and the data is valid only at the rise.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_ARRAY   = 3'd0,
    M_IDENT   = 3'd1,
    M_ERS_ARM = 3'd2,
    M_ERS_VFY = 3'd3,
    M_PRG_ARM = 3'd4,
    M_PRG_VFY = 3'd5
  } mode_e;

  localparam logic [7:0] CMD_READ_Z = 8'h00;
  localparam logic [7:0] CMD_READ_F = 8'hFF;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_EVFY   = 8'hA0;
  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_PVFY   = 8'hC0;

  localparam logic [7:0] ID_MAKER   = 8'h01;
  localparam logic [7:0] ID_DEVICE  = 8'hA7;

  // Identifier byte for the low byte of the read address.
  function automatic logic [7:0] id_byte(input logic [7:0] a_lo);
    case (a_lo)
      8'h00:   return ID_MAKER;
      8'h01:   return ID_DEVICE;
      default: return 8'h00;
    endcase
  endfunction

  // Mode selected by a first-cycle command; unknown bytes keep the mode.
  function automatic mode_e first_cycle_mode(input mode_e cur, input logic [7:0] c);
    case (c)
      CMD_READ_Z, CMD_READ_F: return M_ARRAY;
      CMD_IDENT:              return M_IDENT;
      CMD_ERASE:              return M_ERS_ARM;
      CMD_EVFY:               return M_ERS_VFY;
      CMD_PROG:               return M_PRG_ARM;
      CMD_PVFY:               return M_PRG_VFY;
      default:                return cur;
    endcase
  endfunction

  function automatic logic is_setup(input mode_e m);
    return (m == M_ERS_ARM) || (m == M_PRG_ARM);
  endfunction

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LAST = STAGES - 1;

  logic [2:0]        ctl_pipe  [STAGES];
  logic [ADDR_W-1:0] addr_pipe [STAGES];
  logic [DATA_W-1:0] din_pipe  [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ctl_pipe[0]  <= 3'b111;
            addr_pipe[0] <= '0;
            din_pipe[0]  <= '0;
          end else begin
            ctl_pipe[0]  <= {ce_n, oe_n, we_n};
            addr_pipe[0] <= addr;
            din_pipe[0]  <= din;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ctl_pipe[g]  <= 3'b111;
            addr_pipe[g] <= '0;
            din_pipe[g]  <= '0;
          end else begin
            ctl_pipe[g]  <= ctl_pipe[g-1];
            addr_pipe[g] <= addr_pipe[g-1];
            din_pipe[g]  <= din_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  logic ce_s, oe_s, we_s, we_d;
  assign {ce_s, oe_s, we_s} = ctl_pipe[LAST];

  // Named internal events
  logic bus_sel, we_fall, we_rise;
  logic armed_q;
  logic [ADDR_W-1:0] addr_lat_q;

  assign bus_sel = !ce_s && oe_s;
  assign we_fall = we_d && !we_s && bus_sel;
  assign we_rise = !we_d && we_s && bus_sel && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d       <= 1'b1;
      armed_q    <= 1'b0;
      addr_lat_q <= '0;
      wr_stb     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      we_d   <= we_s;
      wr_stb <= 1'b0;
      if (we_fall) begin
        addr_lat_q <= addr_pipe[LAST];
        armed_q    <= 1'b1;
      end else if (we_rise) begin
        wr_stb  <= 1'b1;
        wr_addr <= addr_lat_q;
        wr_data <= din_pipe[LAST];
        armed_q <= 1'b0;
      end
    end
  end

  assert_one_write_per_pulse_R10: assert property (
    @(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb);

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_e             mode_q,
  output logic              prog_pulse,
  output logic              erase_pulse,
  output logic [ADDR_W-1:0] prog_addr_q,
  output logic [DATA_W-1:0] prog_data_q,
  output logic [ADDR_W-1:0] vfy_addr_q
);
  mode_e             mode_d;
  logic              prog_d, erase_d;
  logic [ADDR_W-1:0] pa_d, va_d;
  logic [DATA_W-1:0] pd_d;

  always_comb begin
    mode_d  = mode_q;
    prog_d  = 1'b0;
    erase_d = 1'b0;
    pa_d    = prog_addr_q;
    pd_d    = prog_data_q;
    va_d    = vfy_addr_q;
    if (wr_stb) begin
      case (mode_q)
        M_ERS_ARM: begin
          erase_d = (wr_data[7:0] == CMD_ERASE);
          mode_d  = M_ARRAY;
        end
        M_PRG_ARM: begin
          prog_d = 1'b1;
          pa_d   = wr_addr;
          pd_d   = wr_data;
          mode_d = M_ARRAY;
        end
        default: begin
          mode_d = first_cycle_mode(mode_q, wr_data[7:0]);
          if (wr_data[7:0] == CMD_EVFY) va_d = wr_addr;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= M_ARRAY;
      prog_pulse  <= 1'b0;
      erase_pulse <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
      vfy_addr_q  <= '0;
    end else begin
      mode_q      <= mode_d;
      prog_pulse  <= prog_d;
      erase_pulse <= erase_d;
      prog_addr_q <= pa_d;
      prog_data_q <= pd_d;
      vfy_addr_q  <= va_d;
    end
  end

  assert_erase_single_R13: assert property (
    @(posedge clk) disable iff (!rst_n) erase_pulse |=> !erase_pulse);

  assert_prog_single_R13: assert property (
    @(posedge clk) disable iff (!rst_n) prog_pulse |=> !prog_pulse);

  assert_erase_after_arm_R3: assert property (
    @(posedge clk) disable iff (!rst_n) erase_pulse |-> ($past(mode_q) == M_ERS_ARM));

  assert_prog_after_arm_R5: assert property (
    @(posedge clk) disable iff (!rst_n) prog_pulse |-> ($past(mode_q) == M_PRG_ARM));

  assert_ident_entry_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
      (wr_stb && !is_setup(mode_q) && wr_data[7:0] == CMD_IDENT) |=> (mode_q == M_IDENT));

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  mode_e             mode,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [ADDR_W-1:0] arr_raddr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    case (mode)
      M_ERS_VFY: arr_raddr = vfy_addr;
      M_PRG_VFY: arr_raddr = prog_addr;
      default:   arr_raddr = addr;
    endcase
  end

  always_comb begin
    rd_val = arr_rdata;
    if (mode == M_IDENT) rd_val = DATA_W'(id_byte(addr[7:0]));
  end

  assign dq_oe  = !ce_n && !oe_n && we_n;
  assign dq_out = dq_oe ? rd_val : '0;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_pulse
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  mode_e             mode;
  logic [ADDR_W-1:0] vfy_addr;

  flash_bus_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(dq_in),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_q(mode), .prog_pulse(prog_pulse), .erase_pulse(erase_pulse),
    .prog_addr_q(prog_addr), .prog_data_q(prog_data), .vfy_addr_q(vfy_addr));

  flash_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .mode(mode), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .vfy_addr(vfy_addr), .prog_addr(prog_addr), .arr_rdata(arr_rdata),
    .arr_raddr(arr_raddr), .dq_out(dq_out), .dq_oe(dq_oe));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out, arr_rdata, prog_data;
  logic        dq_oe, prog_pulse, erase_pulse;
  logic [16:0] arr_raddr, prog_addr;

  int n_tests = 0, n_fail = 0;
  int prog_cnt = 0, erase_cnt = 0, dbl_cnt = 0;
  logic prev_p = 1'b0, prev_e = 1'b0;
  logic [16:0] last_pa = '0;
  logic [7:0]  last_pd = '0;
  logic [7:0]  mem [256];
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .prog_pulse(prog_pulse), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_pulse(erase_pulse));

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd37 + 8'd11;
  endfunction

  assign arr_rdata = mem[arr_raddr[7:0]];

  // Array model and strobe monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
    end else begin
      if (prog_pulse) begin
        mem[prog_addr[7:0]] <= prog_data;
        prog_cnt <= prog_cnt + 1;
        last_pa <= prog_addr;
        last_pd <= prog_data;
      end
      if (erase_pulse) begin
        for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
        erase_cnt <= erase_cnt + 1;
      end
      if ((prog_pulse && prev_p) || (erase_pulse && prev_e)) dbl_cnt <= dbl_cnt + 1;
      prev_p <= prog_pulse;
      prev_e <= erase_pulse;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Address valid only around the falling strobe, data only around the rising one.
  task automatic bus_write(input logic [16:0] a, input logic [7:0] d,
                           input logic ce_v = 1'b0, input logic oe_v = 1'b1);
    @(negedge clk);
    ce_n = ce_v; oe_n = oe_v; addr = a; dq_in = ~d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    addr = ~a; dq_in = d;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; dq_in = ~d;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_read(input logic [16:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
    d = dq_out; oe = dq_oe;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog all-requirements act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic [16:0] a;
    int pc0, ec0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 reset / idle state
    check("R12 idle oe", {31'd0, dq_oe}, 0);
    check("R12 idle data", {24'd0, dq_out}, 0);
    check("R13 no strobes after reset", {30'd0, prog_pulse, erase_pulse}, 0);

    // R1 array read sweep, upper address bits varied
    for (int i = 0; i < 64; i++) begin
      a = 17'((i * 4) | ((i % 2) << 16) | ((i % 3) << 9));
      bus_read(a, d, oe);
      check("R1 array read", {24'd0, d}, {24'd0, pat(a[7:0])});
    end
    check("R12 read enable", {31'd0, oe}, 1);

    // R12 enable combinations
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; #1;
    check("R12 ce high", {31'd0, dq_oe}, 0);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1;
    check("R12 we low", {31'd0, dq_oe}, 0);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2 identifier sweep
    bus_write(17'h1_5555, 8'h90);
    for (int i = 0; i < 8; i++) begin
      bus_read(17'(i | 17'h0_0300), d, oe);
      check("R2 ident byte", {24'd0, d}, (i == 0) ? 32'h01 : (i == 1) ? 32'hA7 : 32'h00);
    end

    // R9 every unrecognised first-cycle byte keeps identifier mode
    for (int v = 0; v < 256; v++) begin
      if (!(v inside {8'h00, 8'hFF, 8'h90, 8'h20, 8'hA0, 8'h40, 8'hC0})) begin
        bus_write(17'h0_0001, 8'(v));
        bus_read(17'h0_0001, d, oe);
        check("R9 unknown keeps mode", {24'd0, d}, 32'hA7);
      end
    end

    // R1 via 00H command
    bus_write(17'h0, 8'h00);
    bus_read(17'h0_0000, d, oe);
    check("R1 cmd 00", {24'd0, d}, {24'd0, pat(8'h00)});

    // R11 writes ignored with chip select high or read strobe low
    bus_write(17'h0, 8'h90, 1'b1, 1'b1);
    bus_read(17'h0_0001, d, oe);
    check("R11 ce high ignored", {24'd0, d}, {24'd0, pat(8'h01)});
    bus_write(17'h0, 8'h90, 1'b0, 1'b0);
    bus_read(17'h0_0001, d, oe);
    check("R11 oe low ignored", {24'd0, d}, {24'd0, pat(8'h01)});

    // R5 / R10 program with address and data valid only at their own strobe edges
    pc0 = prog_cnt;
    bus_write(17'h0_0F0F, 8'h40);
    bus_write(17'h1_0033, 8'h5A);
    check("R5 one program strobe", 32'(prog_cnt - pc0), 1);
    check("R10 address at fall", {15'd0, last_pa}, 32'h1_0033);
    check("R10 data at rise", {24'd0, last_pd}, 32'h5A);
    bus_read(17'h0_0033, d, oe);
    check("R5 programmed byte", {24'd0, d}, 32'h5A);

    // R7 program verify ignores read address
    bus_write(17'h0, 8'hC0);
    bus_read(17'h0_0077, d, oe);
    check("R7 program verify", {24'd0, d}, 32'h5A);

    // R6 erase verify uses the address of the A0H write
    bus_write(17'h0_0012, 8'hA0);
    bus_read(17'h0_0099, d, oe);
    check("R6 erase verify", {24'd0, d}, {24'd0, pat(8'h12)});
    bus_read(17'h1_0044, d, oe);
    check("R6 erase verify again", {24'd0, d}, {24'd0, pat(8'h12)});

    // R4 cancelled erase
    ec0 = erase_cnt;
    bus_write(17'h0, 8'h20);
    bus_write(17'h0, 8'h40);
    check("R4 no erase", 32'(erase_cnt - ec0), 0);
    bus_read(17'h0_0040, d, oe);
    check("R4 back to array", {24'd0, d}, {24'd0, pat(8'h40)});

    // R8 reset from pending erase setup
    pc0 = prog_cnt;
    bus_write(17'h0, 8'h20);
    bus_write(17'h0, 8'hFF);
    bus_write(17'h0, 8'hFF);
    check("R8 no erase on reset", 32'(erase_cnt - ec0), 0);
    check("R8 no program on reset", 32'(prog_cnt - pc0), 0);
    bus_read(17'h0_0041, d, oe);
    check("R8 array after reset", {24'd0, d}, {24'd0, pat(8'h41)});

    // R3 erase
    bus_write(17'h0, 8'h20);
    bus_write(17'h0, 8'h20);
    check("R3 one erase strobe", 32'(erase_cnt - ec0), 1);
    for (int i = 0; i < 4; i++) begin
      bus_read(17'(i * 61), d, oe);
      check("R3 erased array", {24'd0, d}, 32'hFF);
    end

    // R8 reset from identifier mode
    bus_write(17'h0, 8'h90);
    bus_write(17'h0, 8'hFF);
    bus_write(17'h0, 8'hFF);
    bus_read(17'h0_0000, d, oe);
    check("R8 ident left", {24'd0, d}, 32'hFF);

    check("R13 strobe width", 32'(dbl_cnt), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule